// File: doc/BRIEF.md
# Crosswise 4x4 Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and gives an 8-bit product. Each operand is cut into a low and a high 2-bit half. Four small 2x2 multipliers work on the halves at the same time: low by low, the two cross pairs, and high by high. Three 4-bit ripple-carry adders then fold these four sub-products into the final result.

The two lowest result bits come straight from the low-by-low sub-product and pass through no adder. The two cross sub-products are added together first. That sum is then offset by the upper half of the low-by-low sub-product. The last adder takes the high-by-high sub-product and adds the middle sum shifted down by two places, with its carry. A parameter chooses between a registered output, with a fixed one-cycle latency, and a purely combinational path. In both forms a valid strobe travels alongside the operands.

Top module: `vedic_mul4`

## Requirements
- R1: Each 2x2 sub-multiplier gives bit0 = a0&b0. A half adder on a1&b0 and a0&b1 gives bit1 and a carry. A second half adder on a1&b1 and that carry gives bit2 (sum) and bit3 (carry). So 3x3 gives 4'b1001 and 3x1 gives 4'b0011.
- R2: Four sub-multipliers work in parallel on the halves {a[1:0],b[1:0]}, {a[1:0],b[3:2]}, {a[3:2],b[1:0]} and {a[3:2],b[3:2]}.
- R3: product[1:0] always equals the low two bits of a[1:0]*b[1:0].
- R4: Each adder is a chain of one-bit full adders: sum is the XOR of the three inputs, carry is the majority of the three inputs. The first adder sums the two cross sub-products.
- R5: The second adder adds the zero-extended upper two bits of the low-by-low sub-product to the first sum. The carries of the first and second adders are never both set.
- R6: The third adder adds the high-by-high sub-product to the middle sum shifted right by two, carries included. Its output forms product[7:4] and its carry-out is never set.
- R7: For every one of the 256 operand pairs, product equals a*b.
- R8: With REG_OUT=1, out_prod and out_valid change together on the first rising clock edge after the operands are sampled with in_valid high.
- R9: A synchronous active-low reset (rst_n low at a rising edge) clears out_valid and out_prod to zero.
- R10: With REG_OUT=1, a cycle with in_valid low sets out_valid low and leaves out_prod unchanged, whatever the operands are.
- R11: With REG_OUT=0, out_prod and out_valid follow the inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on op_a/op_b are valid |
| op_a | input | 4 | Unsigned multiplicand |
| op_b | input | 4 | Unsigned multiplier |
| out_valid | output | 1 | out_prod holds a new result |
| out_prod | output | 8 | Unsigned product |

## Verification
The exhaustive sweep catches carry-merging faults. A wrong shift or a dropped carry between the second and third adders damages only a few products, such as 15x15 or 13x11. A swapped cross pair changes nothing, because the cross terms are summed. A swapped half, however, shows up on asymmetric operands like 3x12. The 2x2 corner values 3x3 and 3x1 expose a half adder whose carry is fed back as a sum. In the registered form, the latency test samples just before and just after the edge, so an extra or a missing stage is visible. The hold test drives new operands with the strobe low, so a design that loads unconditionally overwrites the product. A reset in the middle of a stream checks that both outputs return to zero.

// File: rtl/vm_pkg.sv
// Shared widths for the crosswise multiplier.
// Assumes even operand width; the structure is built for 4-bit operands.
package vm_pkg;
    localparam int OPW = 4;          // operand width
    localparam int HW  = OPW / 2;    // half-operand width
    localparam int SPW = 2 * HW;     // sub-product width
    localparam int PW  = 2 * OPW;    // product width
    typedef logic [PW-1:0]  prod_t;
    typedef logic [SPW-1:0] sub_t;
endpackage

// File: rtl/vm_half_add.sv
// One-bit half adder: sum is XOR, carry is AND. No assumptions.
module vm_half_add (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    // sum and carry of two bits
    always_comb begin
        s = x ^ y;
        c = x & y;
    end
endmodule

// File: rtl/vm_full_add.sv
// One-bit full adder: XOR sum, majority-of-three carry. No assumptions.
module vm_full_add (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // sum and majority carry
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end
endmodule

// File: rtl/vm_ripple.sv
// W-bit ripple-carry adder built as a serial chain of full adders.
// Assumes W >= 1.
module vm_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] cy;

    // carry enters at bit 0
    always_comb cy[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        vm_full_add u_fa (
            .x (x[i]),
            .y (y[i]),
            .ci(cy[i]),
            .s (s[i]),
            .co(cy[i+1])
        );
    end

    // carry leaves at the top
    always_comb co = cy[W];
endmodule

// File: rtl/vm_cross2.sv
// 2x2 crosswise multiplier: four AND terms, two half adders.
// Output is the full 4-bit unsigned product of two 2-bit values.
module vm_cross2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic t00, t10, t01, t11;
    logic s_mid, c_mid, s_top, c_top;

    // the four partial-product bits
    always_comb begin
        t00 = a[0] & b[0];
        t10 = a[1] & b[0];
        t01 = a[0] & b[1];
        t11 = a[1] & b[1];
    end

    vm_half_add u_ha_mid (.x(t10), .y(t01),   .s(s_mid), .c(c_mid));
    vm_half_add u_ha_top (.x(t11), .y(c_mid), .s(s_top), .c(c_top));

    // pack the sub-product
    always_comb p = {c_top, s_top, s_mid, t00};
endmodule

// File: rtl/vedic_mul4.sv
// Unsigned 4x4 multiplier. Four 2x2 crosswise sub-products are merged
// by three 4-bit ripple adders. REG_OUT=1 registers the result and the
// valid strobe (one-cycle latency); REG_OUT=0 leaves the path combinational.
// Assumes synchronous active-low reset.
module vedic_mul4
    import vm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic           out_valid,
    output logic [PW-1:0]  out_prod
);
    logic [HW-1:0] a_lo, a_hi, b_lo, b_hi;
    sub_t  p_ll, p_lh, p_hl, p_hh;
    sub_t  sum1, sum2, sum3;
    logic  cy1, cy2, cy3, mid_cy;
    prod_t comb_prod;

    // split operands into halves
    always_comb begin
        a_lo = op_a[HW-1:0];
        a_hi = op_a[OPW-1:HW];
        b_lo = op_b[HW-1:0];
        b_hi = op_b[OPW-1:HW];
    end

    vm_cross2 u_ll (.a(a_lo), .b(b_lo), .p(p_ll));
    vm_cross2 u_lh (.a(a_lo), .b(b_hi), .p(p_lh));
    vm_cross2 u_hl (.a(a_hi), .b(b_lo), .p(p_hl));
    vm_cross2 u_hh (.a(a_hi), .b(b_hi), .p(p_hh));

    vm_ripple #(.W(SPW)) u_add1 (
        .x(p_lh), .y(p_hl), .ci(1'b0), .s(sum1), .co(cy1));
    vm_ripple #(.W(SPW)) u_add2 (
        .x(sum1), .y({{(SPW-HW){1'b0}}, p_ll[SPW-1:HW]}), .ci(1'b0),
        .s(sum2), .co(cy2));

    // combined middle carry (cy1 and cy2 are exclusive)
    always_comb mid_cy = cy1 | cy2;

    vm_ripple #(.W(SPW)) u_add3 (
        .x(p_hh), .y({1'b0, mid_cy, sum2[SPW-1:HW]}), .ci(1'b0),
        .s(sum3), .co(cy3));

    // assemble the product
    always_comb comb_prod = {sum3, sum2[HW-1:0], p_ll[HW-1:0]};

    if (REG_OUT) begin : g_reg
        // output register: valid follows strobe, product loads on valid
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_prod  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_prod <= comb_prod;
            end
        end

        a_r8_product_next: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && out_prod == PW'($past(op_a) * $past(op_b))));
        a_r9_reset_clears: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && out_prod == '0));
        a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_prod)));
    end else begin : g_comb
        // combinational pass-through
        always_comb begin
            out_valid = in_valid;
            out_prod  = comb_prod;
        end
    end

    a_r1_low_sub: assert property (@(posedge clk) disable iff (!rst_n)
        p_ll == SPW'(a_lo * b_lo));
    a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        comb_prod[HW-1:0] == HW'(a_lo * b_lo));
    a_r5_single_mid_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !(cy1 && cy2));
    a_r6_top_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !cy3);
    a_r7_exact: assert property (@(posedge clk) disable iff (!rst_n)
        comb_prod == PW'(op_a * op_b));
endmodule

// File: tb/sim_vedic_mul4.sv
module sim_vedic_mul4;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_a = '0, op_b = '0;
    logic       out_valid, c_valid;
    logic [7:0] out_prod, c_prod;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vedic_mul4 #(.REG_OUT(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_prod(out_prod));
    vedic_mul4 #(.REG_OUT(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(c_valid), .out_prod(c_prod));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        in_valid = v; op_a = a; op_b = b;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive(1'b1, 4'd7, 4'd9);
        chk("R9 reset valid", {7'd0, out_valid}, 8'd0);
        chk("R9 reset prod", out_prod, 8'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
    endtask

    task automatic t_sub2x2;
        drive(1'b1, 4'd3, 4'd3);
        chk("R1 3x3", out_prod, 8'b0000_1001);
        drive(1'b1, 4'd3, 4'd1);
        chk("R1 3x1", out_prod, 8'b0000_0011);
        drive(1'b1, 4'd3, 4'd12);          // R2: low x high cross pair
        chk("R2 3x12", out_prod, 8'd36);
        drive(1'b1, 4'd12, 4'd3);
        chk("R2 12x3", out_prod, 8'd36);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(1'b1, 4'(i), 4'(j));
                // R4 R5 R6 merge chain, R7 full product
                chk("R7 product", out_prod, 8'(i * j));
                chk("R3 low bits", {6'd0, out_prod[1:0]}, 8'((i % 4) * (j % 4) % 4));
            end
        end
        drive(1'b1, 4'd15, 4'd15);
        chk("R6 15x15 top", out_prod, 8'd225);
        drive(1'b1, 4'd13, 4'd11);
        chk("R5 13x11", out_prod, 8'd143);
    endtask

    task automatic t_latency;
        drive(1'b1, 4'd2, 4'd2);
        @(negedge clk);
        in_valid = 1'b1; op_a = 4'd5; op_b = 4'd6;
        #1;
        chk("R8 before edge", out_prod, 8'd4);
        @(posedge clk); #1;
        chk("R8 after edge", out_prod, 8'd30);
        chk("R8 valid", {7'd0, out_valid}, 8'd1);
    endtask

    task automatic t_hold;
        drive(1'b0, 4'd15, 4'd15);
        chk("R10 hold prod", out_prod, 8'd30);
        chk("R10 valid low", {7'd0, out_valid}, 8'd0);
        drive(1'b0, 4'd9, 4'd9);
        chk("R10 still held", out_prod, 8'd30);
    endtask

    task automatic t_comb;
        @(negedge clk);
        in_valid = 1'b1; op_a = 4'd11; op_b = 4'd7;
        #1;
        chk("R11 comb prod", c_prod, 8'd77);
        chk("R11 comb valid", {7'd0, c_valid}, 8'd1);
        in_valid = 1'b0; op_a = 4'd4; #1;
        chk("R11 comb follow", c_prod, 8'd28);
        chk("R11 comb invalid", {7'd0, c_valid}, 8'd0);
    endtask

    task automatic t_reset_mid;
        drive(1'b1, 4'd9, 4'd9);
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(posedge clk); #1;
        chk("R9 mid reset prod", out_prod, 8'd0);
        chk("R9 mid reset valid", {7'd0, out_valid}, 8'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sub2x2();
        t_sweep();
        t_latency();
        t_hold();
        t_comb();
        t_reset_mid();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule